// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block controls up to seven banks of 32 general-purpose pins through a 32-bit register bus with address, write strobe, write data and read data. Each pin has an output latch, a direction bit, and rising- and falling-edge enables. Each pin also has a sticky edge-status bit and an interrupt mask bit. Software changes the output latch only through separate write-one-set and write-one-clear registers. Several agents can therefore change different pins without a read-modify-write sequence.

Each input passes through a two-flop synchroniser before it can be read or checked for edges. An enabled edge sets a status bit, and the bit stays set until software writes a one to it. One combined interrupt reports any unmasked pending edge in any bank. Pins 0 and 1 of bank 0 each also have their own interrupt line. Reads of the bus are combinational and return data in the same cycle as the address.

Top module: `banked_gpio`

## Requirements
- R1: Bank n's registers start at byte address (n/3)*0x100 + (n%3)*4. From that start the registers are:
  - level at +0x00
  - direction at +0x0C
  - set at +0x18
  - clear at +0x24
  - rising enable at +0x30
  - falling enable at +0x3C
  - edge status at +0x48
  - interrupt mask at +0x9C

  Reads of the set and clear registers, of unmapped offsets, and of banks at or beyond the bank count return zero.
- R2: A write to the set register makes every output bit high whose write-data bit is 1. Bits written as 0 keep their value.
- R3: A write to the clear register makes every output bit low whose write-data bit is 1. Bits written as 0 keep their value.
- R4: A direction bit of 1 enables the pin's output driver (`pin_oe` high), and 0 makes the pin an input. The direction register reads back what was written.
- R5: The level register returns each pin's input after two clock edges of synchronisation, whatever the pin's direction.
- R6: A rising transition of a synchronised input sets its status bit when that pin's rising enable is 1. A pin without the matching enable never gains a status bit.
- R7: A falling transition sets the status bit when the falling enable is 1.
- R8: Writing a 1 to a status bit clears that bit. Writing 0 has no effect, and writing all ones clears the whole bank.
- R9: When an edge is detected in the same cycle as a write-one clear of that bit, the bit stays set.
- R10: `irq_any` is high exactly when some status bit is set whose interrupt mask bit is 1. When every mask bit is 0, the output stays low.
- R11: `irq_pin0` and `irq_pin1` follow the masked status of bank 0 bits 0 and 1, and each implies `irq_any`.
- R12: After reset, the following are all zero and no interrupt is raised:
  - output latches
  - direction bits
  - edge enables
  - status bits
  - mask bits
  - synchroniser flops

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NB*32 | Raw pin inputs, bank n in bits [32n+31:32n] |
| pin_out | output | NB*32 | Output latches |
| pin_oe | output | NB*32 | Output enables (direction bits) |
| irq_any | output | 1 | Any unmasked pending edge in any bank |
| irq_pin0 | output | 1 | Unmasked pending edge on bank 0 pin 0 |
| irq_pin1 | output | 1 | Unmasked pending edge on bank 0 pin 1 |

## Verification
The hardest case to reach is a status bit that is cleared by software in the same cycle that a new edge is detected on it. This happens only when the clear write lands exactly two edges after the pin change, because the change must first cross the synchroniser. The stimulus first leaves the bit set and drops the pin with no falling enable. It then raises the pin again at a falling clock edge and places the clear write two falling edges later, which lines it up with the edge-detection cycle. A behavioural model keeps a short history of the pin inputs, so both this case and the one-cycle staleness of level reads are predicted on every clock.

// File: rtl/banked_gpio.sv
module banked_gpio #(
  parameter int NB = 7,
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NB*32-1:0]  pin_in,
  output logic [NB*32-1:0]  pin_out,
  output logic [NB*32-1:0]  pin_oe,
  output logic              irq_any,
  output logic              irq_pin0,
  output logic              irq_pin1
);
  localparam int NP = NB * 32;
  localparam logic [7:0] O_LVL = 8'h00;
  localparam logic [7:0] O_DIR = 8'h0C;
  localparam logic [7:0] O_SET = 8'h18;
  localparam logic [7:0] O_CLR = 8'h24;
  localparam logic [7:0] O_REN = 8'h30;
  localparam logic [7:0] O_FEN = 8'h3C;
  localparam logic [7:0] O_STS = 8'h48;
  localparam logic [7:0] O_MSK = 8'h9C;

  logic [NP-1:0] s1_q, lvl_q, prv_q;
  logic [NP-1:0] out_q, dir_q, ren_q, fen_q, sts_q, msk_q;
  logic [NP-1:0] set_v, clr_v, ack_v;
  logic [NB-1:0] w_dir, w_ren, w_fen, w_msk;
  logic [NP-1:0] rise_hit, fall_hit;

  function automatic logic [AW-1:0] bank_base(input int b);
    return AW'((b / 3) * 256 + (b % 3) * 4);
  endfunction

  function automatic logic hit(input logic [AW-1:0] a, input int b, input logic [7:0] off);
    return a == bank_base(b) + AW'(off);
  endfunction

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NB; b++) begin
      set_v[b*32 +: 32] = (bus_we && hit(bus_addr, b, O_SET)) ? bus_wdata : 32'h0;
      clr_v[b*32 +: 32] = (bus_we && hit(bus_addr, b, O_CLR)) ? bus_wdata : 32'h0;
      ack_v[b*32 +: 32] = (bus_we && hit(bus_addr, b, O_STS)) ? bus_wdata : 32'h0;
      w_dir[b] = bus_we && hit(bus_addr, b, O_DIR);
      w_ren[b] = bus_we && hit(bus_addr, b, O_REN);
      w_fen[b] = bus_we && hit(bus_addr, b, O_FEN);
      w_msk[b] = bus_we && hit(bus_addr, b, O_MSK);
      if (hit(bus_addr, b, O_LVL)) bus_rdata = lvl_q[b*32 +: 32];
      if (hit(bus_addr, b, O_DIR)) bus_rdata = dir_q[b*32 +: 32];
      if (hit(bus_addr, b, O_REN)) bus_rdata = ren_q[b*32 +: 32];
      if (hit(bus_addr, b, O_FEN)) bus_rdata = fen_q[b*32 +: 32];
      if (hit(bus_addr, b, O_STS)) bus_rdata = sts_q[b*32 +: 32];
      if (hit(bus_addr, b, O_MSK)) bus_rdata = msk_q[b*32 +: 32];
    end
  end

  assign rise_hit = lvl_q & ~prv_q & ren_q;
  assign fall_hit = ~lvl_q & prv_q & fen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= '0;
      lvl_q <= '0;
      prv_q <= '0;
      out_q <= '0;
      dir_q <= '0;
      ren_q <= '0;
      fen_q <= '0;
      sts_q <= '0;
      msk_q <= '0;
    end else begin
      s1_q  <= pin_in;
      lvl_q <= s1_q;
      prv_q <= lvl_q;
      out_q <= (out_q | set_v) & ~clr_v;
      sts_q <= (sts_q & ~ack_v) | rise_hit | fall_hit;
      for (int b = 0; b < NB; b++) begin
        if (w_dir[b]) dir_q[b*32 +: 32] <= bus_wdata;
        if (w_ren[b]) ren_q[b*32 +: 32] <= bus_wdata;
        if (w_fen[b]) fen_q[b*32 +: 32] <= bus_wdata;
        if (w_msk[b]) msk_q[b*32 +: 32] <= bus_wdata;
      end
    end
  end

  assign pin_out  = out_q;
  assign pin_oe   = dir_q;
  assign irq_any  = |(sts_q & msk_q);
  assign irq_pin0 = sts_q[0] & msk_q[0];
  assign irq_pin1 = sts_q[1] & msk_q[1];
endmodule

// File: rtl/banked_gpio_checker.sv
module banked_gpio_checker #(
  parameter int NB = 7,
  parameter int AW = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_we,
  input logic [31:0]      bus_wdata,
  input logic [NB*32-1:0] pin_out,
  input logic             irq_any,
  input logic             irq_pin0,
  input logic             irq_pin1,
  input logic [NB*32-1:0] sts_q,
  input logic [NB*32-1:0] ren_q,
  input logic [NB*32-1:0] fen_q,
  input logic [NB*32-1:0] msk_q
);
  assert_set_bank0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'('h018)) |=>
      (pin_out[31:0] == ($past(pin_out[31:0]) | $past(bus_wdata))));

  assert_clr_bank0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'('h024)) |=>
      (pin_out[31:0] == ($past(pin_out[31:0]) & ~$past(bus_wdata))));

  assert_edge_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q & ~$past(sts_q)) & ~$past(ren_q | fen_q)) == '0);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == AW'('h048)) |=>
      ((sts_q[31:0] & $past(sts_q[31:0])) == $past(sts_q[31:0])));

  assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_q == '0) |-> !irq_any);

  assert_pin0_in_any_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pin0 |-> irq_any);

  assert_pin1_in_any_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pin1 |-> irq_any);
endmodule

bind banked_gpio banked_gpio_checker #(.NB(NB), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .irq_any(irq_any),
  .irq_pin0(irq_pin0), .irq_pin1(irq_pin1), .sts_q(sts_q),
  .ren_q(ren_q), .fen_q(fen_q), .msk_q(msk_q)
);

// File: tb/banked_gpio_test.sv
module banked_gpio_test;
  localparam int NB = 7;
  localparam int AW = 10;
  localparam int NP = NB * 32;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_we = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic irq_any, irq_pin0, irq_pin1;

  int tests = 0, fails = 0;

  banked_gpio #(.NB(NB), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_any(irq_any),
    .irq_pin0(irq_pin0), .irq_pin1(irq_pin1));

  always #2 clk = ~clk;

  logic [NP-1:0] m_out, m_dir, m_ren, m_fen, m_sts, m_msk;
  logic [NP-1:0] hist[$];

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // rid: 0 level, 1 dir, 2 set, 3 clear, 4 rise en, 5 fall en, 6 status, 7 mask
  function automatic int decode(input logic [AW-1:0] a, output int rid);
    int off, k, bank;
    rid = -1;
    off = int'(a[7:0]);
    if (a[1:0] != 2'b00) return -1;
    if (off < 'h54) begin rid = off / 12; k = (off % 12) / 4; end
    else if (off >= 'h9C && off <= 'hA4) begin rid = 7; k = (off - 'h9C) / 4; end
    else return -1;
    bank = int'(a[9:8]) * 3 + k;
    if (bank >= NB) begin rid = -1; return -1; end
    return bank;
  endfunction

  function automatic logic [31:0] model_rd(input logic [AW-1:0] a);
    int rid, b;
    b = decode(a, rid);
    if (b < 0) return 32'h0;
    case (rid)
      0: return hist[1][b*32 +: 32];
      1: return m_dir[b*32 +: 32];
      4: return m_ren[b*32 +: 32];
      5: return m_fen[b*32 +: 32];
      6: return m_sts[b*32 +: 32];
      7: return m_msk[b*32 +: 32];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_out = '0; m_dir = '0; m_ren = '0; m_fen = '0; m_sts = '0; m_msk = '0;
      hist = '{'0, '0, '0};
    end else begin
      logic [NP-1:0] cur, prv, rise, fall, ack;
      int rid, b;
      cur = hist[1];
      prv = hist[2];
      rise = cur & ~prv & m_ren;
      fall = ~cur & prv & m_fen;
      ack = '0;
      if (bus_we) begin
        b = decode(bus_addr, rid);
        if (b >= 0) case (rid)
          1: m_dir[b*32 +: 32] = bus_wdata;
          2: m_out[b*32 +: 32] = m_out[b*32 +: 32] | bus_wdata;
          3: m_out[b*32 +: 32] = m_out[b*32 +: 32] & ~bus_wdata;
          4: m_ren[b*32 +: 32] = bus_wdata;
          5: m_fen[b*32 +: 32] = bus_wdata;
          6: ack[b*32 +: 32] = bus_wdata;
          7: m_msk[b*32 +: 32] = bus_wdata;
          default: ;
        endcase
      end
      m_sts = (m_sts & ~ack) | rise | fall;
      hist.push_front(pin_in);
      void'(hist.pop_back());
    end
    #1;
    chk("R2/R3 pin_out", pin_out, m_out);
    chk("R4 pin_oe", pin_oe, m_dir);
    chk("R10 irq_any", irq_any, |(m_sts & m_msk));
    chk("R11 irq_pin0", irq_pin0, m_sts[0] & m_msk[0]);
    chk("R11 irq_pin1", irq_pin1, m_sts[1] & m_msk[1]);
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    @(negedge clk); bus_addr = a; bus_we = 0;
    #1 chk(tag, bus_rdata, model_rd(a));
  endtask

  task automatic rd_lit(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_addr = a; bus_we = 0;
    #1 chk(tag, bus_rdata, exp);
  endtask

  task automatic pins(input int b, input logic [31:0] v);
    @(negedge clk); pin_in[b*32 +: 32] = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12: reset state of banks 0 and 6
    for (int i = 0; i < 8; i++) begin
      rd_lit(AW'(i * 12), 32'h0, "R12 bank0 reset");
      rd_lit(AW'('h200 + i * 12), 32'h0, "R12 bank6 reset");
    end
    rd_lit(AW'('h09C), 32'h0, "R12 mask reset");
    // R1: holes and absent banks
    rd_lit(AW'('h054), 32'h0, "R1 unmapped 0x054");
    rd_lit(AW'('h0A8), 32'h0, "R1 unmapped 0x0A8");
    rd_lit(AW'('h204), 32'h0, "R1 absent bank 7");
    rd_lit(AW'('h300), 32'h0, "R1 absent group");
    // R2 / R3
    wr(AW'('h01C), 32'hA5A5_0001);
    wr(AW'('h218), 32'h8000_0000);
    rd_lit(AW'('h01C), 32'h0, "R1 set reads zero");
    chk("R2 bank1 out", pin_out[63:32], 32'hA5A5_0001);
    chk("R2 bank6 out", pin_out[223:192], 32'h8000_0000);
    wr(AW'('h028), 32'h0000_0101);
    chk("R3 bank1 out", pin_out[63:32], 32'hA5A5_0000);
    // R4
    wr(AW'('h10C), 32'hFFFF_0000);
    rd_lit(AW'('h10C), 32'hFFFF_0000, "R4 dir readback");
    chk("R4 bank3 oe", pin_oe[127:96], 32'hFFFF_0000);
    // R5: level stale one cycle, then valid; output pins too
    pins(4, 32'h1234_5678);
    rd(AW'('h104), "R5 level in flight");
    idle(2);
    rd_lit(AW'('h104), 32'h1234_5678, "R5 level bank4");
    pins(3, 32'hCAFE_0000);
    idle(3);
    rd_lit(AW'('h100), 32'hCAFE_0000, "R5 level on output pins");
    // R6 / R11
    wr(AW'('h09C), 32'hFFFF_FFFF);
    wr(AW'('h030), 32'h0000_0023);
    pins(0, 32'h0000_0025);
    idle(4);
    rd_lit(AW'('h048), 32'h0000_0021, "R6 rise status");
    chk("R11 pin0 irq", irq_pin0, 1'b1);
    chk("R11 pin1 quiet", irq_pin1, 1'b0);
    pins(0, 32'h0000_0027);
    idle(4);
    rd_lit(AW'('h048), 32'h0000_0023, "R6 rise pin1");
    chk("R11 pin1 irq", irq_pin1, 1'b1);
    // R7
    wr(AW'('h044), 32'h0000_00F0);
    pins(2, 32'h0000_00FF);
    idle(4);
    rd_lit(AW'('h050), 32'h0, "R7 no status on rise");
    pins(2, 32'h0000_000F);
    idle(4);
    rd_lit(AW'('h050), 32'h0000_00F0, "R7 fall status");
    wr(AW'('h0A4), 32'hFFFF_FFFF);
    // R8
    wr(AW'('h048), 32'h0);
    rd_lit(AW'('h048), 32'h0000_0023, "R8 zero write no effect");
    wr(AW'('h048), 32'h0000_0020);
    rd_lit(AW'('h048), 32'h0000_0003, "R8 single clear");
    wr(AW'('h048), 32'hFFFF_FFFF);
    rd_lit(AW'('h048), 32'h0, "R8 clear all");
    chk("R10 bank2 pending", irq_any, 1'b1);
    wr(AW'('h050), 32'hFFFF_FFFF);
    chk("R10 nothing pending", irq_any, 1'b0);
    // R10: mask gates pending status
    pins(0, 32'h0);
    idle(4);
    pins(0, 32'h0000_0020);
    idle(4);
    chk("R10 unmasked irq", irq_any, 1'b1);
    wr(AW'('h09C), 32'h0);
    chk("R10 masked irq", irq_any, 1'b0);
    rd_lit(AW'('h048), 32'h0000_0020, "R10 status kept under mask");
    wr(AW'('h09C), 32'hFFFF_FFFF);
    // R9: edge coincides with its own clear
    pins(0, 32'h0);
    idle(4);
    rd_lit(AW'('h048), 32'h0000_0020, "R9 setup still pending");
    pins(0, 32'h0000_0020);
    @(negedge clk);
    @(negedge clk); bus_addr = AW'('h048); bus_we = 1; bus_wdata = 32'h0000_0020;
    @(negedge clk); bus_we = 0;
    rd_lit(AW'('h048), 32'h0000_0020, "R9 edge wins over clear");
    wr(AW'('h048), 32'h0000_0020);
    rd_lit(AW'('h048), 32'h0, "R9 later clear works");
    idle(2);
    summary();
  end
endmodule